// File: doc/BRIEF.md
# Shared address/data bus sequencer

This block is a bus master for a peripheral whose address and data travel over the same I/O lines. A host hands it one request at a time. Each request carries a 32-bit address, a 32-bit write word or a read flag, a port-width code, and a parity-polarity bit. The block drives the address onto the shared lines as one, two or four beats, depending on the port width. It then moves the data in the same number of beats and holds a single active-low chip select for the whole transfer. On reads it stops driving the lines for one cycle before the data phase. It then samples each returned beat and rebuilds the 32-bit read word.

Every beat carries a parity bit, and the request sets it to even or odd. The block generates parity on the beats it drives and checks it on the beats it receives. A mismatch on any read beat sets an error flag that is reported with the completion pulse.

The request side is a valid/ready stream. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. Until then the host must hold the request and its fields steady. Back-pressure lasts from the acceptance edge until the cycle after the completion pulse. Completion is a plain one-cycle pulse with no handshake.

Top module: `muxbus_seq`

## Requirements
- R1: After reset the block is idle: `bus_cs_n`=1, `bus_ale`=0, `bus_oe`=0, `bus_rd`=0, `bus_dout`=0, `bus_par_out`=0, `req_ready`=1, `rsp_done`=0.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both high. All request fields are captured at that edge, and later changes have no effect on the transfer. The first address beat appears in the cycle after the accepting edge.
- R3: Width code 0 means an 8-bit port with 4 beats per phase. Code 1 means a 16-bit port with 2 beats. Codes 2 and 3 mean a 32-bit port with 1 beat. All address beats come first, then all data beats. Each phase sends its most significant portion first. Each beat occupies `bus_dout[W-1:0]`, with the upper lines zero, and lasts BEAT_CYC cycles.
- R4: `bus_ale` is high in every address-beat cycle and low in every other cycle.
- R5: `bus_cs_n` is low from the first address-beat cycle through the last data-beat cycle, and high otherwise. `bus_rd` is high in those same cycles for a read and low otherwise.
- R6: On every driven beat, `bus_par_out` equals the XOR of the active lines XOR the polarity bit (1 = odd). It is 0 whenever the block does not drive.
- R7: For a write, `bus_oe` is high on all address and data beats. For a read, `bus_oe` is high on the address beats, then low for one turnaround cycle with the chip select still active, then low through all data beats.
- R8: On a read, `bus_din[W-1:0]` is sampled in the last cycle of each data beat. The samples are assembled most significant portion first into `rsp_rdata`. Lines above the port width have no effect on data or parity.
- R9: `rsp_perr` is high at completion of a read exactly when some data beat had (XOR of active `bus_din` lines XOR `bus_par_in`) different from the polarity bit. After a write it is 0.
- R10: `rsp_done` is high for exactly one cycle, the cycle after the last data beat. `req_ready` is low in that cycle, so a request already waiting is taken on the following edge. `rsp_rdata` and `rsp_perr` hold until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_width | input | 2 | Port width code (0 = 8, 1 = 16, 2/3 = 32 bits) |
| req_odd | input | 1 | Parity polarity, 1 = odd, 0 = even |
| req_addr | input | 32 | Transfer address |
| req_wdata | input | 32 | Write word |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read word |
| rsp_perr | output | 1 | Read parity mismatch seen |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_ale | output | 1 | High during address beats |
| bus_oe | output | 1 | Block drives the shared lines |
| bus_rd | output | 1 | Direction of the current transfer, 1 = read |
| bus_dout | output | 32 | Shared-line value driven by the block |
| bus_par_out | output | 1 | Parity driven with each beat |
| bus_din | input | 32 | Shared-line value from the device |
| bus_par_in | input | 1 | Parity returned with each read beat |

## Verification
Two events can fall in the same cycle: the completion pulse and a new request that is already waiting. The bench keeps `req_valid` high for the whole transfer, with scrambled field values. In the done cycle it checks that `req_ready` is low. It then checks that the next, correct request is taken one edge later. Because the scrambled fields are present throughout, capture at acceptance is also confirmed beat by beat. A parity error injected on the final read beat is judged in that same done cycle. This shows that the last sample and the completion flag do not race.

// File: rtl/muxbus_pkg.sv
`timescale 1ns/1ps
package muxbus_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned QTR_W  = WORD_W / 4;
  localparam int unsigned HALF_W = WORD_W / 2;

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_TURN, ST_DATA, ST_DONE} seq_state_t;

  function automatic logic [2:0] beats_for(input logic [1:0] code);
    case (code)
      2'd0:    beats_for = 3'd4;
      2'd1:    beats_for = 3'd2;
      default: beats_for = 3'd1;
    endcase
  endfunction

  function automatic int unsigned lane_bits(input logic [1:0] code);
    case (code)
      2'd0:    lane_bits = QTR_W;
      2'd1:    lane_bits = HALF_W;
      default: lane_bits = WORD_W;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] lane_mask(input logic [1:0] code);
    case (code)
      2'd0:    lane_mask = {{(WORD_W-QTR_W){1'b0}}, {QTR_W{1'b1}}};
      2'd1:    lane_mask = {{(WORD_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
      default: lane_mask = {WORD_W{1'b1}};
    endcase
  endfunction

  // bit offset of beat k when the top portion goes first
  function automatic int unsigned beat_shift(input logic [1:0] code, input logic [1:0] beat);
    int unsigned nb;
    nb = int'(beats_for(code));
    beat_shift = (nb - 1 - int'(beat)) * lane_bits(code);
  endfunction
endpackage

// File: rtl/muxbus_ctrl.sv
`timescale 1ns/1ps
module muxbus_ctrl
  import muxbus_pkg::*;
#(
  parameter int unsigned BEAT_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_read,
  input  logic [2:0] nbeats,
  output seq_state_t state,
  output logic [1:0] beat_idx,
  output logic       beat_end
);
  localparam int unsigned CW = (BEAT_CYC > 1) ? $clog2(BEAT_CYC) : 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(BEAT_CYC - 1);

  logic [CW-1:0] cyc;
  logic          last_beat;

  assign beat_end  = (state == ST_ADDR || state == ST_DATA) && (cyc == CYC_LAST);
  assign last_beat = ({1'b0, beat_idx} == (nbeats - 3'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cyc      <= '0;
      beat_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_ADDR;
          cyc      <= '0;
          beat_idx <= '0;
        end
        ST_ADDR: begin
          if (beat_end) begin
            cyc <= '0;
            if (last_beat) begin
              beat_idx <= '0;
              state    <= is_read ? ST_TURN : ST_DATA;
            end else begin
              beat_idx <= beat_idx + 2'd1;
            end
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        ST_TURN: state <= ST_DATA;
        ST_DATA: begin
          if (beat_end) begin
            cyc <= '0;
            if (last_beat) begin
              beat_idx <= '0;
              state    <= ST_DONE;
            end else begin
              beat_idx <= beat_idx + 2'd1;
            end
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/muxbus_lane.sv
`timescale 1ns/1ps
module muxbus_lane
  import muxbus_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        code,
  input  logic [1:0]        beat_idx,
  input  logic              odd,
  input  logic              en,
  output logic [WORD_W-1:0] lanes,
  output logic              par
);
  logic [WORD_W-1:0] shifted;

  always_comb begin
    shifted = word >> beat_shift(code, beat_idx);
    if (en) begin
      lanes = shifted & lane_mask(code);
      par   = (^lanes) ^ odd;
    end else begin
      lanes = '0;
      par   = 1'b0;
    end
  end
endmodule

// File: rtl/muxbus_rx.sv
`timescale 1ns/1ps
module muxbus_rx
  import muxbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic [WORD_W-1:0] din,
  input  logic              par_in,
  input  logic [1:0]        code,
  input  logic              odd,
  output logic [WORD_W-1:0] rdata,
  output logic              perr
);
  logic [WORD_W-1:0] active;
  logic              bad;

  assign active = din & lane_mask(code);
  assign bad    = ((^active) ^ par_in) != odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      perr  <= 1'b0;
    end else if (clear) begin
      rdata <= '0;
      perr  <= 1'b0;
    end else if (sample) begin
      rdata <= (rdata << lane_bits(code)) | active;
      perr  <= perr | bad;
    end
  end
endmodule

// File: rtl/muxbus_seq.sv
`timescale 1ns/1ps
module muxbus_seq
  import muxbus_pkg::*;
#(
  parameter int unsigned BEAT_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [1:0]  req_width,
  input  logic        req_odd,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_done,
  output logic [31:0] rsp_rdata,
  output logic        rsp_perr,
  output logic        bus_cs_n,
  output logic        bus_ale,
  output logic        bus_oe,
  output logic        bus_rd,
  output logic [31:0] bus_dout,
  output logic        bus_par_out,
  input  logic [31:0] bus_din,
  input  logic        bus_par_in
);
  seq_state_t        state;
  logic [1:0]        beat_idx;
  logic              beat_end;
  logic              accept;
  logic [WORD_W-1:0] l_addr, l_wdata;
  logic              l_write, l_odd;
  logic [1:0]        l_code;
  logic              drive;
  logic              busy;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_addr  <= '0;
      l_wdata <= '0;
      l_write <= 1'b0;
      l_odd   <= 1'b0;
      l_code  <= '0;
    end else if (accept) begin
      l_addr  <= req_addr;
      l_wdata <= req_wdata;
      l_write <= req_write;
      l_odd   <= req_odd;
      l_code  <= req_width;
    end
  end

  muxbus_ctrl #(.BEAT_CYC(BEAT_CYC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .is_read  (!l_write),
    .nbeats   (beats_for(l_code)),
    .state    (state),
    .beat_idx (beat_idx),
    .beat_end (beat_end)
  );

  assign drive = (state == ST_ADDR) || (state == ST_DATA && l_write);
  assign busy  = (state == ST_ADDR) || (state == ST_TURN) || (state == ST_DATA);

  muxbus_lane u_lane (
    .word     ((state == ST_ADDR) ? l_addr : l_wdata),
    .code     (l_code),
    .beat_idx (beat_idx),
    .odd      (l_odd),
    .en       (drive),
    .lanes    (bus_dout),
    .par      (bus_par_out)
  );

  muxbus_rx u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .sample ((state == ST_DATA) && beat_end && !l_write),
    .din    (bus_din),
    .par_in (bus_par_in),
    .code   (l_code),
    .odd    (l_odd),
    .rdata  (rsp_rdata),
    .perr   (rsp_perr)
  );

  assign bus_cs_n = !busy;
  assign bus_ale  = (state == ST_ADDR);
  assign bus_oe   = drive;
  assign bus_rd   = busy && !l_write;
  assign rsp_done = (state == ST_DONE);
endmodule

// File: rtl/muxbus_chk.sv
`timescale 1ns/1ps
module muxbus_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_done,
  input logic bus_cs_n,
  input logic bus_ale,
  input logic bus_oe,
  input logic bus_rd
);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  a_r10_busy_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !req_ready && bus_cs_n);
  a_r2_accept_starts_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!bus_cs_n && bus_ale && bus_oe));
  a_r5_ready_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_cs_n);
  a_r4_ale_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (!bus_cs_n && bus_oe));
  a_r7_drive_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !bus_cs_n);
  a_r5_release_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> rsp_done);
  a_r5_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_rd));
endmodule

bind muxbus_seq muxbus_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .bus_cs_n  (bus_cs_n),
  .bus_ale   (bus_ale),
  .bus_oe    (bus_oe),
  .bus_rd    (bus_rd)
);

// File: tb/tb_muxbus_seq.sv
`timescale 1ns/1ps
module tb_muxbus_seq;
  localparam int B = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_odd = 1'b0;
  logic [1:0]  req_width = '0;
  logic [31:0] req_addr = '0, req_wdata = '0, bus_din = '0;
  logic        bus_par_in = 1'b0;
  logic        req_ready, rsp_done, rsp_perr, bus_cs_n, bus_ale, bus_oe, bus_rd, bus_par_out;
  logic [31:0] rsp_rdata, bus_dout;
  int          nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  muxbus_seq #(.BEAT_CYC(B)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_width(req_width), .req_odd(req_odd),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr), .bus_cs_n(bus_cs_n),
    .bus_ale(bus_ale), .bus_oe(bus_oe), .bus_rd(bus_rd), .bus_dout(bus_dout),
    .bus_par_out(bus_par_out), .bus_din(bus_din), .bus_par_in(bus_par_in)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic xfer(input logic [1:0] code, input bit wr, input bit odd,
                      input logic [31:0] addr, input logic [31:0] data, input int bad);
    int nb, lb, total, nph;
    logic [31:0] mask, ex, sl;
    bit eale, eoe, epar;
    nb   = (code == 0) ? 4 : (code == 1) ? 2 : 1;
    lb   = 32 / nb;
    mask = (lb == 32) ? 32'hFFFF_FFFF : ((32'd1 << lb) - 1);
    nph  = nb * B;
    total = 2 * nph + (wr ? 0 : 1);
    check(req_ready == 1'b1, "R2 ready while idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_width = code; req_odd = odd;
    req_addr = addr; req_wdata = data;
    @(posedge clk); @(negedge clk);
    // scramble fields while valid stays high: must have no effect (R2)
    req_addr = ~addr; req_wdata = ~data; req_width = ~code; req_odd = ~odd; req_write = ~wr;
    for (int t = 0; t < total; t++) begin
      bus_din = 32'hC3A5_5A3C ^ (t * 32'h0101_0101);
      bus_par_in = t[0];
      if (t < nph) begin
        ex = (addr >> ((nb - 1 - t / B) * lb)) & mask;
        eale = 1; eoe = 1; epar = (^ex) ^ odd;
      end else if (!wr && t == nph) begin
        ex = 0; eale = 0; eoe = 0; epar = 0;
      end else begin
        int d, k;
        d = t - nph - (wr ? 0 : 1);
        k = d / B;
        sl = (data >> ((nb - 1 - k) * lb)) & mask;
        eale = 0;
        if (wr) begin
          ex = sl; eoe = 1; epar = (^sl) ^ odd;
        end else begin
          ex = 0; eoe = 0; epar = 0;
          bus_din = sl | (~mask & bus_din);
          bus_par_in = (^sl) ^ odd ^ (k == bad);
        end
      end
      #1;
      check(bus_cs_n == 1'b0, "R5 select active", {31'd0, bus_cs_n}, 32'd0);
      check(bus_rd == !wr, "R5 direction", {31'd0, bus_rd}, {31'd0, !wr});
      check(bus_ale == eale, "R4 ale", {31'd0, bus_ale}, {31'd0, eale});
      check(bus_oe == eoe, "R7 output enable", {31'd0, bus_oe}, {31'd0, eoe});
      check(bus_dout == ex, "R3 beat value", bus_dout, ex);
      check(bus_par_out == epar, "R6 parity out", {31'd0, bus_par_out}, {31'd0, epar});
      check(rsp_done == 1'b0 && req_ready == 1'b0, "R10 busy no done",
            {30'd0, rsp_done, req_ready}, 32'd0);
      @(negedge clk);
    end
    // done cycle: completion coincides with a waiting request
    check(rsp_done == 1'b1, "R10 done pulse", {31'd0, rsp_done}, 32'd1);
    check(req_ready == 1'b0, "R10 not ready in done cycle", {31'd0, req_ready}, 32'd0);
    check(bus_cs_n == 1'b1 && bus_oe == 1'b0, "R5 released at done",
          {30'd0, bus_cs_n, bus_oe}, 32'd2);
    if (!wr) check(rsp_rdata == data, "R8 read assembly", rsp_rdata, data);
    check(rsp_perr == (!wr && bad >= 0), "R9 parity flag",
          {31'd0, rsp_perr}, {31'd0, (!wr && bad >= 0)});
    @(negedge clk);
    check(rsp_done == 1'b0 && req_ready == 1'b1 && bus_cs_n == 1'b1, "R10 single pulse, back to idle",
          {29'd0, rsp_done, req_ready, bus_cs_n}, 32'd3);
    if (!wr) check(rsp_rdata == data, "R10 read data held", rsp_rdata, data);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R10 watchdog actual hung expected completion");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_cs_n == 1 && bus_ale == 0 && bus_oe == 0 && bus_rd == 0,
          "R1 reset bus idle", {28'd0, bus_cs_n, bus_ale, bus_oe, bus_rd}, 32'h8);
    check(bus_dout == 0 && bus_par_out == 0, "R1 reset lines zero", bus_dout, 32'd0);
    check(req_ready == 1 && rsp_done == 0, "R1 reset handshake",
          {30'd0, req_ready, rsp_done}, 32'd2);
    for (int code = 0; code < 4; code++)
      for (int wr = 0; wr < 2; wr++)
        for (int odd = 0; odd < 2; odd++)
          for (int p = 0; p < 6; p++) begin
            logic [31:0] a, d;
            int nb, bad;
            nb = (code == 0) ? 4 : (code == 1) ? 2 : 1;
            a = (p == 0) ? 32'h0 : 32'h9E37_79B9 * (p + 1) + code;
            d = (p == 0) ? 32'hFFFF_FFFF : (32'h7F4A_7C15 * (p + 3)) ^ {odd[7:0], 24'h0};
            bad = (p % (nb + 1)) - 1;   // -1 means clean; else beat index to corrupt
            if (p == 5) bad = nb - 1;   // error on final beat, same cycle window as done
            xfer(code[1:0], wr[0], odd[0], a, d, bad);
          end
    req_valid = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1 && bus_cs_n == 1'b1, "R2 idle after last request",
          {30'd0, req_ready, bus_cs_n}, 32'd3);
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule